// File: doc/BRIEF.md
# Deinterlacer Output Frame Sequencer

This block is the output stage of a field-to-frame deinterlacer. It runs on the core clock, which is also the output pixel clock and runs at twice the input pixel rate. It reads finished output lines from a small ring of line buffers and sends them out as a 4:2:0 stream. Luma and the Cb/Cr pair travel on separate paths, and each path has its own valid strobe. Upstream logic gives the block a frame marker at the start of each input field and a line-ready pulse each time one output line has been written into the buffer ring. Each input field produces one output frame.

Output for a frame is held back until two output lines are in the buffer. This is the point where the first input line has been fully processed. After that, each line is read out as soon as the line two positions ahead of it has been written. The last two lines of a frame are read out once every line of the frame is written. A two-bit rate code thins the output stream by whole frames, for full, half, quarter or eighth rate. The block samples the code only when a frame marker arrives.

Top module: `deint_out_seq`

## Requirements
- R1: After reset, and until the first frame marker, every valid strobe, the start-of-frame flag, the end-of-line flag and the read enable stay low, whatever happens on line-ready.
- R2: Within a kept frame no line is read until two line-ready pulses have been seen. Once the second pulse is sampled, the read enable rises one cycle later and luma valid rises two cycles later.
- R3: Line n (counted from 0) starts only when min(n+2, LINES) lines of the current frame have been reported ready. Lines are read in order, one pixel per cycle, with a single idle cycle between lines.
- R4: While the read enable is high, the read address is {line mod BUF_LINES, pixel index}. The line slot is in the upper bits and the pixel index in the lower $clog2(PIX) bits. Luma valid follows each read by exactly one cycle, with the buffer's read data passed to the luma output.
- R5: Chroma valid is high only together with luma valid, on even lines (line 0 is even) and at even pixel positions. A full frame therefore gives (LINES/2)*(PIX/2) chroma beats. The Cb/Cr pair comes from the same read as the luma.
- R6: The start-of-frame flag is high exactly once per kept frame, together with the luma valid of line 0, pixel 0.
- R7: The end-of-line flag is high together with the luma valid of the last pixel of each line, and at no other time.
- R8: Rate code 0, 1, 2 or 3 keeps frame k (counted from 0 after reset) exactly when k mod 1, 2, 4 or 8 is 0. A skipped frame produces no reads and no valids.
- R9: The rate code is sampled only when a frame marker arrives. A change in the middle of a frame does not affect that frame.
- R10: Reset restarts the frame count, so the first frame after any reset is always kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core / output pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_i | input | 2 | Frame-rate code: 0 full, 1 half, 2 quarter, 3 eighth |
| field_start_i | input | 1 | One-cycle marker at the start of each input field |
| line_ready_i | input | 1 | One-cycle pulse when an output line is written into the buffer ring |
| rd_en_o | output | 1 | Line-buffer read enable |
| rd_addr_o | output | $clog2(BUF_LINES)+$clog2(PIX) | Line-buffer read address {slot, pixel} |
| rd_y_i | input | Y_W | Luma read data, one cycle after the read |
| rd_c_i | input | C_W | Cb/Cr pair read data, one cycle after the read |
| y_o | output | Y_W | Output luma |
| y_valid_o | output | 1 | Luma valid |
| c_o | output | C_W | Output Cb/Cr pair |
| c_valid_o | output | 1 | Chroma valid |
| sof_o | output | 1 | Start of kept frame, with its first luma beat |
| eol_o | output | 1 | Last luma beat of a line |

## Verification
The bench builds the block with PIX=8, LINES=4 and BUF_LINES=4. With these values a whole frame is 32 luma beats, and each pixel maps to a unique 5-bit buffer address, so every beat's data can be traced to its line and pixel. Four lines per frame means the hold-off, the steady one-line lag and the drain of the last two lines all occur in a single frame of a few dozen cycles. Eight frames per rate code are enough to cover a full period of the 3-bit frame counter at eighth rate.

// File: rtl/deint_out_pkg.sv
package deint_out_pkg;

  typedef enum logic [1:0] {
    RATE_FULL    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_EIGHTH  = 2'd3
  } rate_e;

  // frames kept when (count & mask) == 0
  function automatic logic [2:0] rate_mask(input logic [1:0] code);
    logic [3:0] one_hot;
    one_hot = 4'd1 << code;
    return 3'(one_hot - 4'd1);
  endfunction

endpackage

// File: rtl/deint_frame_decim.sv
module deint_frame_decim
  import deint_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       field_start_i,
  input  logic [1:0] rate_i,
  output logic       keep_o,
  output logic [1:0] rate_o
);

  logic [2:0] fcnt_q;
  logic       keep_q;
  logic [1:0] rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      keep_q <= 1'b0;
      rate_q <= RATE_FULL;
    end else if (field_start_i) begin
      rate_q <= rate_i;
      keep_q <= (fcnt_q & rate_mask(rate_i)) == 3'd0;
      fcnt_q <= fcnt_q + 3'd1;
    end
  end

  assign keep_o = keep_q;
  assign rate_o = rate_q;

endmodule

// File: rtl/deint_line_gate.sv
module deint_line_gate #(
  parameter int LINES  = 576,
  parameter int LCNT_W = $clog2(LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              field_start_i,
  input  logic              line_ready_i,
  input  logic              start_i,
  output logic              start_ok_o,
  output logic [LCNT_W-1:0] line_idx_o
);

  localparam logic [LCNT_W:0] LinesX = (LCNT_W + 1)'(LINES);

  logic [LCNT_W-1:0] wcnt_q, ecnt_q;
  logic [LCNT_W:0]   ahead_w, need_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (field_start_i) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      if (line_ready_i && (wcnt_q != LCNT_W'(LINES))) wcnt_q <= wcnt_q + 1'b1;
      if (start_i) ecnt_q <= ecnt_q + 1'b1;
    end
  end

  // line n needs n+2 lines written, or the whole frame near its end
  assign ahead_w    = {1'b0, ecnt_q} + (LCNT_W + 1)'(2);
  assign need_w     = (ahead_w > LinesX) ? LinesX : ahead_w;
  assign start_ok_o = ({1'b0, ecnt_q} < LinesX) && ({1'b0, wcnt_q} >= need_w);
  assign line_idx_o = ecnt_q;

endmodule

// File: rtl/deint_pix_scan.sv
module deint_pix_scan #(
  parameter int PIX       = 720,
  parameter int BUF_LINES = 4,
  parameter int LCNT_W    = 10,
  parameter int PIX_W     = $clog2(PIX),
  parameter int SLOT_W    = $clog2(BUF_LINES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    field_start_i,
  input  logic                    keep_i,
  input  logic                    start_ok_i,
  input  logic [LCNT_W-1:0]       line_idx_i,
  output logic                    start_o,
  output logic                    rd_en_o,
  output logic [SLOT_W+PIX_W-1:0] rd_addr_o,
  output logic                    y_valid_o,
  output logic                    c_valid_o,
  output logic                    sof_o,
  output logic                    eol_o
);

  localparam logic [PIX_W-1:0] LastPix = PIX_W'(PIX - 1);

  logic              busy_q;
  logic [PIX_W-1:0]  pix_q;
  logic [LCNT_W-1:0] line_q;
  logic              yv_q, cv_q, sof_q, eol_q;

  assign start_o = !busy_q && keep_i && start_ok_i && !field_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else if (field_start_i) begin
      busy_q <= 1'b0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      pix_q  <= '0;
      line_q <= line_idx_i;
    end else if (busy_q) begin
      if (pix_q == LastPix) busy_q <= 1'b0;
      else                  pix_q  <= pix_q + 1'b1;
    end
  end

  // strobes line up with the one-cycle buffer read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yv_q  <= 1'b0;
      cv_q  <= 1'b0;
      sof_q <= 1'b0;
      eol_q <= 1'b0;
    end else begin
      yv_q  <= busy_q;
      cv_q  <= busy_q && !line_q[0] && !pix_q[0];
      sof_q <= busy_q && (line_q == '0) && (pix_q == '0);
      eol_q <= busy_q && (pix_q == LastPix);
    end
  end

  assign rd_en_o   = busy_q;
  assign rd_addr_o = {line_q[SLOT_W-1:0], pix_q};
  assign y_valid_o = yv_q;
  assign c_valid_o = cv_q;
  assign sof_o     = sof_q;
  assign eol_o     = eol_q;

endmodule

// File: rtl/deint_out_seq.sv
module deint_out_seq #(
  parameter int Y_W       = 8,
  parameter int C_W       = 16,
  parameter int PIX       = 720,
  parameter int LINES     = 576,
  parameter int BUF_LINES = 4,
  parameter int PIX_W     = $clog2(PIX),
  parameter int SLOT_W    = $clog2(BUF_LINES),
  parameter int ADDR_W    = SLOT_W + PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rate_i,
  input  logic              field_start_i,
  input  logic              line_ready_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [Y_W-1:0]    rd_y_i,
  input  logic [C_W-1:0]    rd_c_i,
  output logic [Y_W-1:0]    y_o,
  output logic              y_valid_o,
  output logic [C_W-1:0]    c_o,
  output logic              c_valid_o,
  output logic              sof_o,
  output logic              eol_o
);

  localparam int LcntW = $clog2(LINES + 1);

  logic             keep_w;
  logic [1:0]       rate_w;
  logic             start_ok_w, start_w;
  logic [LcntW-1:0] line_idx_w;

  deint_frame_decim u_decim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .field_start_i(field_start_i),
    .rate_i       (rate_i),
    .keep_o       (keep_w),
    .rate_o       (rate_w)
  );

  deint_line_gate #(
    .LINES (LINES),
    .LCNT_W(LcntW)
  ) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .field_start_i(field_start_i),
    .line_ready_i (line_ready_i),
    .start_i      (start_w),
    .start_ok_o   (start_ok_w),
    .line_idx_o   (line_idx_w)
  );

  deint_pix_scan #(
    .PIX      (PIX),
    .BUF_LINES(BUF_LINES),
    .LCNT_W   (LcntW),
    .PIX_W    (PIX_W),
    .SLOT_W   (SLOT_W)
  ) u_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .field_start_i(field_start_i),
    .keep_i       (keep_w),
    .start_ok_i   (start_ok_w),
    .line_idx_i   (line_idx_w),
    .start_o      (start_w),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .y_valid_o    (y_valid_o),
    .c_valid_o    (c_valid_o),
    .sof_o        (sof_o),
    .eol_o        (eol_o)
  );

  // buffer read data is registered at the buffer; forward it
  assign y_o = rd_y_i;
  assign c_o = rd_c_i;

endmodule

// File: rtl/deint_out_seq_chk.sv
module deint_out_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       field_start_i,
  input logic       rd_en_o,
  input logic       y_valid_o,
  input logic       c_valid_o,
  input logic       sof_o,
  input logic       eol_o,
  input logic       keep_w,
  input logic [1:0] rate_w
);

  p_read_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> $past(rd_en_o));

  p_chroma_in_luma_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |-> y_valid_o);

  p_sof_with_luma_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> y_valid_o);

  p_eol_with_luma_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> y_valid_o);

  p_skip_no_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep_w |-> !rd_en_o);

  p_rate_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_start_i |=> $stable(rate_w));

endmodule

bind deint_out_seq deint_out_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .field_start_i(field_start_i),
  .rd_en_o      (rd_en_o),
  .y_valid_o    (y_valid_o),
  .c_valid_o    (c_valid_o),
  .sof_o        (sof_o),
  .eol_o        (eol_o),
  .keep_w       (keep_w),
  .rate_w       (rate_w)
);

// File: tb/deint_out_seq_test.sv
`timescale 1ns/1ps
module deint_out_seq_test;

  localparam int PIX = 8;
  localparam int LINES = 4;
  localparam int BUF_LINES = 4;
  localparam int FRAME_Y = PIX * LINES;
  localparam int FRAME_C = (LINES / 2) * (PIX / 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate = 2'd0;
  logic        fs = 1'b0;
  logic        lr = 1'b0;
  logic        rd_en;
  logic [4:0]  rd_addr;
  logic [7:0]  rd_y;
  logic [15:0] rd_c;
  logic [7:0]  y;
  logic        y_valid;
  logic [15:0] c;
  logic        c_valid;
  logic        sof;
  logic        eol;

  int checks = 0;
  int errors = 0;
  int yc, cc, ec, sofc, rdc, derr, cerr, eerr, stray;
  int ml = 0;
  int mp = 0;

  always #5 clk = ~clk;

  deint_out_seq #(.Y_W(8), .C_W(16), .PIX(PIX), .LINES(LINES), .BUF_LINES(BUF_LINES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate), .field_start_i(fs), .line_ready_i(lr),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_y_i(rd_y), .rd_c_i(rd_c),
    .y_o(y), .y_valid_o(y_valid), .c_o(c), .c_valid_o(c_valid), .sof_o(sof), .eol_o(eol)
  );

  // line-buffer model with one-cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      rd_y <= 8'(rd_addr * 5 + 3);
      rd_c <= 16'(rd_addr * 7 + 100);
    end
  end

  // output monitor, own position tracking
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) rdc++;
      if (y_valid) begin
        int ea;
        bit expc;
        if (sof) begin ml = 0; mp = 0; sofc++; end
        ea = (ml % BUF_LINES) * PIX + mp;
        if (y !== 8'(ea * 5 + 3)) derr++;
        expc = (ml % 2 == 0) && (mp % 2 == 0);
        if (c_valid !== expc) cerr++;
        else if (c_valid && (c !== 16'(ea * 7 + 100))) cerr++;
        if (eol !== (mp == PIX - 1)) eerr++;
        yc++;
        if (c_valid) cc++;
        if (eol) ec++;
        mp++;
        if (mp == PIX) begin mp = 0; ml++; end
      end else if (c_valid || sof || eol) stray++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    yc = 0; cc = 0; ec = 0; sofc = 0; rdc = 0;
    derr = 0; cerr = 0; eerr = 0; stray = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    fs = 1'b0; lr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    clr();
  endtask

  task automatic pulse_fs();
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
  endtask

  task automatic pulse_lr();
    @(negedge clk) lr = 1'b1;
    @(negedge clk) lr = 1'b0;
  endtask

  task automatic frame();
    pulse_fs();
    repeat (LINES) begin
      pulse_lr();
      cyc(12);
    end
    cyc(20);
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk("R1 y_valid", int'(y_valid), 0);
    chk("R1 c_valid", int'(c_valid), 0);
    chk("R1 sof|eol", int'(sof | eol), 0);
    chk("R1 rd_en", int'(rd_en), 0);
    repeat (3) begin pulse_lr(); cyc(12); end
    chk("R1 no reads before frame marker", rdc, 0);
    chk("R1 no luma before frame marker", yc, 0);
  endtask

  task automatic t_holdoff();
    do_reset();
    rate = 2'd0;
    pulse_fs();
    pulse_lr();
    cyc(20);
    chk("R2 no output after one line", yc + rdc, 0);
    pulse_lr();
    chk("R2 luma low at pulse sample", int'(y_valid), 0);
    @(posedge clk); #1;
    chk("R2 read enable one cycle later", int'(rd_en), 1);
    chk("R2 luma still low", int'(y_valid), 0);
    chk("R4 first address", int'(rd_addr), 0);
    @(posedge clk); #1;
    chk("R2 luma valid two cycles later", int'(y_valid), 1);
    chk("R6 sof on first beat", int'(sof), 1);
    cyc(20);
    chk("R3 only line 0 after two lines", yc, PIX);
    pulse_lr();
    cyc(20);
    chk("R3 line 1 after three lines", yc, 2 * PIX);
    pulse_lr();
    cyc(30);
    chk("R3 drain of last two lines", yc, FRAME_Y);
    chk("R4 luma data and order", derr, 0);
    chk("R4 reads equal beats", rdc, FRAME_Y);
    chk("R5 chroma placement and data", cerr, 0);
    chk("R5 chroma beat count", cc, FRAME_C);
    chk("R6 sof once", sofc, 1);
    chk("R7 eol placement", eerr, 0);
    chk("R7 eol count", ec, LINES);
    chk("R5 R6 R7 no stray markers", stray, 0);
  endtask

  task automatic t_decim(input logic [1:0] code);
    int period;
    period = 1 << code;
    do_reset();
    rate = code;
    for (int k = 0; k < 8; k++) begin
      frame();
      chk($sformatf("R8 rate %0d frame %0d luma", code, k), yc, (k % period == 0) ? FRAME_Y : 0);
      chk($sformatf("R8 rate %0d frame %0d reads", code, k), rdc, (k % period == 0) ? FRAME_Y : 0);
      chk($sformatf("R8 rate %0d frame %0d sof", code, k), sofc, (k % period == 0) ? 1 : 0);
      chk("R8 data", derr + cerr + eerr + stray, 0);
      clr();
    end
  endtask

  task automatic t_rate_sample();
    do_reset();
    rate = 2'd0;
    pulse_fs();
    rate = 2'd3;
    repeat (LINES) begin pulse_lr(); cyc(12); end
    cyc(20);
    chk("R9 mid-frame change ignored", yc, FRAME_Y);
    clr();
    frame();
    chk("R9 new code applies next frame", yc, 0);
    clr();
    frame();
    chk("R9 eighth rate still skipping", yc, 0);
    clr();
  endtask

  task automatic t_reset_restart();
    do_reset();
    rate = 2'd2;
    frame();
    chk("R10 frame 0 kept", yc, FRAME_Y);
    clr();
    frame();
    chk("R10 frame 1 skipped", yc, 0);
    do_reset();
    frame();
    chk("R10 first frame after reset kept", yc, FRAME_Y);
    chk("R10 sof after reset", sofc, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr();
    t_reset_idle();
    t_holdoff();
    for (int r = 0; r < 4; r++) t_decim(2'(r));
    t_rate_sample();
    t_reset_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule